// File: doc/BRIEF.md
# Enclosure LED Serial Pattern Shifter

The block keeps a packed pattern of three LED bits (activity, locate, fault) for each drive port of a storage controller. It turns each per-port LED update request into a frame on a three-wire serial link (clock, load, data) to an external LED controller. A request carries a port number and a 32-bit state word. The port number picks a slot from a configurable mapping table. The state word sets that slot's three pattern bits. After each accepted update the whole pattern is shifted out, least significant bit first.

Each frame starts with a configurable number of plain clock pulses. A load pulse follows, then three data bits per configured port, then a configurable number of trailing pulses. A pulse is a high half-period followed by a low half-period, and the length of a half-period is set in system-clock cycles. A request that arrives while a frame is on the wire updates the pattern at once and asks for one more frame, so several such requests fold into a single later frame. A request whose slot field is out of range is rejected with an error pulse. The last accepted state word is kept for each port and slot and can be read back.

Top module: `sgpio_led_serializer`

## Requirements
- R1: Port p owns pattern bits 3*s (activity), 3*s+1 (locate) and 3*s+2 (fault), where s is the 3-bit entry `cfg_slot_map[3p+2:3p]`. An update touches no other bit.
- R2: On an accepted request, activity becomes state[20] OR state[21], locate becomes state[19] and fault becomes state[22]. Each of the three is cleared when its source is clear, and all other state bits have no effect on the pattern.
- R3: When state[15:8] is not below PM_SLOTS (4), `req_err` is high in the cycle after the request. The pattern and the stored state stay unchanged, and no frame is sent.
- R4: Every clock pulse holds `sclk` high for HALF_CYC cycles and then low for HALF_CYC cycles.
- R5: A frame is `cfg_pre` plain pulses, then one pulse with `sload` high (rising with that pulse's clock and falling when it ends), then 3*`cfg_nports` pulses carrying pattern bits from bit 0 upward on `sdata` (`sload` low), then `cfg_post` plain pulses.
- R6: After reset `sclk`, `sload` and `sdata` are all high. Between frames all three lines hold their levels.
- R7: With `cfg_pre` and `cfg_post` at zero, a frame holds only the load pulse and the data pulses.
- R8: A request sampled at clock edge k on an idle block raises `busy` and `sclk` at edge k+1. `busy` falls when the low half of the frame's last pulse ends.
- R9: Requests accepted while `busy` is high update the pattern immediately. They cause exactly one further frame, which carries the pattern after the last of them.
- R10: `rd_state` shows the state word last accepted for port `rd_port` and slot field value `rd_slot`, and is zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | LED update request strobe |
| req_port | input | 3 | Port the request addresses |
| req_state | input | 32 | LED state word |
| cfg_nports | input | 4 | Ports sent per frame (clamped to N_PORTS) |
| cfg_slot_map | input | 24 | Slot of each port, 3 bits per port |
| cfg_pre | input | 8 | Plain pulses before the load pulse |
| cfg_post | input | 8 | Plain pulses after the data |
| rd_port | input | 3 | Port for stored-state readback |
| rd_slot | input | 2 | Slot field value for readback |
| rd_state | output | 32 | Stored state word |
| busy | output | 1 | Frame in progress |
| req_err | output | 1 | Rejected-request pulse |
| sclk | output | 1 | Serial clock line |
| sload | output | 1 | Serial load line |
| sdata | output | 1 | Serial data line |

## Verification
The assertions assume that the configuration inputs (`cfg_nports`, `cfg_slot_map`, `cfg_pre`, `cfg_post`) stay constant while `busy` is high. They also assume that every mapped slot is below N_SLOTS. The stimulus changes configuration only after `busy` has been seen low for several cycles, and it uses slot maps that are permutations of 0 to 7. Rejected requests are sent only while the block is idle, so a check that no frame follows cannot be hidden by a frame already on the wire.

// File: rtl/sgpio_led_serializer.sv
module sgpio_led_serializer #(
  parameter int N_PORTS  = 8,
  parameter int N_SLOTS  = 8,
  parameter int PM_SLOTS = 4,
  parameter int HALF_CYC = 2500,
  parameter int CNT_W    = 8
) (
  input  logic                                                   clk,
  input  logic                                                   rst_n,
  input  logic                                                   req_valid,
  input  logic [((N_PORTS > 1) ? $clog2(N_PORTS) : 1)-1:0]       req_port,
  input  logic [31:0]                                            req_state,
  input  logic [$clog2(N_PORTS+1)-1:0]                           cfg_nports,
  input  logic [N_PORTS*((N_SLOTS > 1) ? $clog2(N_SLOTS) : 1)-1:0] cfg_slot_map,
  input  logic [CNT_W-1:0]                                       cfg_pre,
  input  logic [CNT_W-1:0]                                       cfg_post,
  input  logic [((N_PORTS > 1) ? $clog2(N_PORTS) : 1)-1:0]       rd_port,
  input  logic [((PM_SLOTS > 1) ? $clog2(PM_SLOTS) : 1)-1:0]     rd_slot,
  output logic [31:0]                                            rd_state,
  output logic                                                   busy,
  output logic                                                   req_err,
  output logic                                                   sclk,
  output logic                                                   sload,
  output logic                                                   sdata
);
  localparam int PAT_W  = 3 * N_SLOTS;
  localparam int SLOT_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1;
  localparam int PM_W   = (PM_SLOTS > 1) ? $clog2(PM_SLOTS) : 1;
  localparam int NP_W   = $clog2(N_PORTS + 1);
  localparam int HC_W   = $clog2(HALF_CYC + 1);
  localparam int PI_W   = $clog2(PAT_W);
  localparam int BIT_W  = $clog2(PAT_W + 1);
  localparam int PC_W   = (CNT_W > BIT_W) ? CNT_W : BIT_W;

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_LOAD, S_DATA, S_POST} phase_t;

  phase_t            st;
  logic [HC_W-1:0]   hcnt;
  logic [PC_W-1:0]   pcnt;
  logic [PAT_W-1:0]  pattern;
  logic [PAT_W-1:0]  shreg;
  logic              pend;
  logic [31:0]       store [N_PORTS][PM_SLOTS];

  wire [7:0]        pm_field = req_state[15:8];
  wire              slot_ok  = 32'(pm_field) < PM_SLOTS;
  wire              accept   = req_valid && slot_ok;
  wire [SLOT_W-1:0] slot     = cfg_slot_map[req_port*SLOT_W +: SLOT_W];
  wire [PI_W-1:0]   base     = PI_W'(3 * slot);
  wire              unused_state = ^{req_state[31:23], req_state[7:0]};

  wire [NP_W-1:0]   np_eff   = (cfg_nports > NP_W'(N_PORTS)) ? NP_W'(N_PORTS) : cfg_nports;
  wire [PC_W-1:0]   nbits    = PC_W'(3 * np_eff);
  wire [PC_W-1:0]   next_cnt = pcnt + PC_W'(1);
  wire              half_end = hcnt == HC_W'(HALF_CYC - 1);
  wire              start    = (st == S_IDLE) && pend;

  assign busy     = st != S_IDLE;
  assign rd_state = store[rd_port][rd_slot];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pattern <= '0;
      pend    <= 1'b0;
      req_err <= 1'b0;
      for (int p = 0; p < N_PORTS; p++)
        for (int s = 0; s < PM_SLOTS; s++)
          store[p][s] <= '0;
    end else begin
      req_err <= req_valid && !slot_ok;
      pend    <= accept || (pend && !start);
      if (accept) begin
        pattern[base]             <= req_state[21] | req_state[20];
        pattern[base + PI_W'(1)]  <= req_state[19];
        pattern[base + PI_W'(2)]  <= req_state[22];
        store[req_port][pm_field[PM_W-1:0]] <= req_state;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      hcnt  <= '0;
      pcnt  <= '0;
      shreg <= '0;
      sclk  <= 1'b1;
      sload <= 1'b1;
      sdata <= 1'b1;
    end else if (start) begin
      shreg <= pattern;
      hcnt  <= '0;
      pcnt  <= '0;
      sclk  <= 1'b1;
      if (cfg_pre != '0) begin
        st    <= S_PRE;
        sload <= 1'b0;
      end else begin
        st    <= S_LOAD;
        sload <= 1'b1;
      end
    end else if (busy) begin
      if (!half_end) begin
        hcnt <= hcnt + HC_W'(1);
      end else begin
        hcnt <= '0;
        if (sclk) begin
          sclk <= 1'b0;
        end else begin
          case (st)
            S_PRE: begin
              sclk <= 1'b1;
              if (next_cnt == PC_W'(cfg_pre)) begin
                st    <= S_LOAD;
                sload <= 1'b1;
                pcnt  <= '0;
              end else begin
                pcnt <= next_cnt;
              end
            end
            S_LOAD: begin
              sload <= 1'b0;
              pcnt  <= '0;
              if (nbits != '0) begin
                st    <= S_DATA;
                sclk  <= 1'b1;
                sdata <= shreg[0];
                shreg <= shreg >> 1;
              end else if (cfg_post != '0) begin
                st   <= S_POST;
                sclk <= 1'b1;
              end else begin
                st <= S_IDLE;
              end
            end
            S_DATA: begin
              if (next_cnt == nbits) begin
                pcnt <= '0;
                if (cfg_post != '0) begin
                  st   <= S_POST;
                  sclk <= 1'b1;
                end else begin
                  st <= S_IDLE;
                end
              end else begin
                pcnt  <= next_cnt;
                sclk  <= 1'b1;
                sdata <= shreg[0];
                shreg <= shreg >> 1;
              end
            end
            S_POST: begin
              if (next_cnt == PC_W'(cfg_post)) begin
                st   <= S_IDLE;
                pcnt <= '0;
              end else begin
                pcnt <= next_cnt;
                sclk <= 1'b1;
              end
            end
            default: st <= S_IDLE;
          endcase
        end
      end
    end
  end

  a_r1_pattern_only_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(pattern));

  a_r3_reject_keeps_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> $stable(pattern));

  a_r5_load_rises_with_clock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sload) |-> (sclk && busy));

  a_r6_idle_lines_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !pend) |=> $stable({sclk, sload, sdata}));

  a_r8_frame_opens_high: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> sclk);

  a_r9_busy_request_pends: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && busy) |=> pend);

endmodule

// File: tb/tb_sgpio_led_serializer.sv
module tb_sgpio_led_serializer;
  localparam int HALF = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [2:0]  req_port;
  logic [31:0] req_state;
  logic [3:0]  cfg_nports;
  logic [23:0] cfg_slot_map;
  logic [7:0]  cfg_pre, cfg_post;
  logic [2:0]  rd_port;
  logic [1:0]  rd_slot;
  logic [31:0] rd_state;
  logic        busy, req_err, sclk, sload, sdata;

  always #2 clk = ~clk;

  sgpio_led_serializer #(.HALF_CYC(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_port(req_port),
    .req_state(req_state), .cfg_nports(cfg_nports), .cfg_slot_map(cfg_slot_map),
    .cfg_pre(cfg_pre), .cfg_post(cfg_post), .rd_port(rd_port), .rd_slot(rd_slot),
    .rd_state(rd_state), .busy(busy), .req_err(req_err), .sclk(sclk),
    .sload(sload), .sdata(sdata));

  int          total = 0;
  int          bad = 0;
  string       tag = "R6";
  int          q[$];
  logic [23:0] exp_pat = '0;
  logic [31:0] exp_store [8][4];
  bit          finished = 0;

  task automatic chk(input bit ok, input string t, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", t, what, act, exp);
    end
  endtask

  function automatic void set_map(input bit rev);
    for (int p = 0; p < 8; p++) cfg_slot_map[p*3 +: 3] = rev ? 3'(7 - p) : 3'(p);
  endfunction

  function automatic void push_frame(input logic [23:0] pat);
    for (int i = 0; i < int'(cfg_pre); i++) q.push_back(0);
    q.push_back(3'b010);
    for (int i = 0; i < 3 * int'(cfg_nports); i++) q.push_back({1'b1, 1'b0, pat[i]});
    for (int i = 0; i < int'(cfg_post); i++) q.push_back(0);
  endfunction

  function automatic void model(input int port, input logic [31:0] st);
    int pm = int'(st[15:8]);
    int s;
    if (pm < 4) begin
      s = int'(cfg_slot_map[port*3 +: 3]);
      exp_pat[3*s]   = st[21] | st[20];
      exp_pat[3*s+1] = st[19];
      exp_pat[3*s+2] = st[22];
      exp_store[port][pm] = st;
    end
  endfunction

  task automatic send(input int port, input logic [31:0] st, input bit chk_start);
    @(negedge clk);
    req_valid = 1'b1;
    req_port  = 3'(port);
    req_state = st;
    @(negedge clk);
    req_valid = 1'b0;
    if (chk_start) begin
      chk(busy == 1'b0, "R8", "busy before start edge", busy, 0);
      @(negedge clk);
      chk(busy == 1'b1, "R8", "busy after start edge", busy, 1);
      chk(sclk == 1'b1, "R8", "sclk after start edge", sclk, 1);
    end
  endtask

  task automatic wait_idle();
    do begin
      while (busy) @(negedge clk);
      repeat (4) @(negedge clk);
    end while (busy);
  endtask

  // scoreboard monitor: pops one expected pulse per observed clock pulse
  initial begin
    logic psclk = 1'b1;
    logic pbusy = 1'b0;
    int   hl = 0;
    int   ll = 0;
    int   it;
    forever begin
      @(negedge clk);
      if (rst_n === 1'b1) begin
        if (busy && sclk && (!psclk || !pbusy)) begin
          if (pbusy) chk(ll == HALF, "R4", "low half length", ll, HALF);
          hl = 1;
          if (q.size() == 0) begin
            chk(1'b0, tag, "unexpected pulse", 1, 0);
          end else begin
            it = q.pop_front();
            chk(sload == it[1], tag, "load level on pulse", sload, it[1]);
            if (it[2]) chk(sdata == it[0], tag, "data bit on pulse", sdata, it[0]);
          end
        end else if (busy && sclk && psclk) begin
          hl++;
        end
        if (!sclk && psclk && pbusy) begin
          chk(hl == HALF, "R4", "high half length", hl, HALF);
          ll = 1;
        end else if (!sclk && !psclk && busy) begin
          ll++;
        end
        if (!busy && pbusy) chk(ll == HALF, "R4", "final low half length", ll, HALF);
      end
      psclk = sclk;
      pbusy = busy;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [2:0] lines;
    for (int p = 0; p < 8; p++) for (int s = 0; s < 4; s++) exp_store[p][s] = '0;
    rst_n = 1'b0; req_valid = 1'b0; req_port = '0; req_state = '0;
    cfg_nports = 4'd8; set_map(1'b1); cfg_pre = '0; cfg_post = '0;
    rd_port = '0; rd_slot = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    chk({sclk, sload, sdata} == 3'b111, "R6", "lines after reset", {sclk, sload, sdata}, 3'b111);
    chk(busy == 1'b0, "R6", "busy after reset", busy, 0);
    chk(req_err == 1'b0, "R3", "err after reset", req_err, 0);
    chk(rd_state == 32'h0, "R10", "stored state after reset", rd_state, 0);

    // R1 and R7: port 0 maps to slot 7, no extra pulses
    tag = "R1";
    model(0, 32'h0020_0000);
    push_frame(exp_pat);
    send(0, 32'h0020_0000, 1'b1);
    wait_idle();
    chk(exp_pat == 24'h20_0000, "R1", "model sanity slot 7", exp_pat, 24'h20_0000);

    tag = "R6";
    lines = {sclk, sload, sdata};
    chk(lines[2:1] == 2'b00, "R6", "clock and load low after frame", lines[2:1], 0);
    repeat (10) @(negedge clk);
    chk({sclk, sload, sdata} == lines, "R6", "lines hold while idle", {sclk, sload, sdata}, lines);

    // R2: decoding of the state word
    tag = "R2";
    model(2, 32'h0048_0000);
    push_frame(exp_pat);
    send(2, 32'h0048_0000, 1'b0);
    wait_idle();
    model(2, 32'h0010_0000);
    push_frame(exp_pat);
    send(2, 32'h0010_0000, 1'b0);
    wait_idle();
    model(0, 32'hFF87_00FF);
    push_frame(exp_pat);
    send(0, 32'hFF87_00FF, 1'b0);
    wait_idle();

    // R3: out-of-range slot field
    tag = "R3";
    send(5, 32'h0040_0400, 1'b0);
    chk(req_err == 1'b1, "R3", "err after bad slot", req_err, 1);
    @(negedge clk);
    chk(req_err == 1'b0, "R3", "err is one cycle", req_err, 0);
    begin
      bit seen = 0;
      repeat (20) begin
        @(negedge clk);
        if (busy) seen = 1;
      end
      chk(seen == 0, "R3", "no frame after reject", seen, 0);
    end
    rd_port = 3'd5; rd_slot = 2'd0;
    @(negedge clk);
    chk(rd_state == exp_store[5][0], "R3", "store untouched by reject", rd_state, exp_store[5][0]);
    model(6, 32'h0000_0000);
    push_frame(exp_pat);
    send(6, 32'h0000_0000, 1'b0);
    wait_idle();

    // R10: stored state readback per port and slot field
    tag = "R10";
    model(1, 32'h0008_0300);
    push_frame(exp_pat);
    send(1, 32'h0008_0300, 1'b0);
    wait_idle();
    rd_port = 3'd1; rd_slot = 2'd3;
    @(negedge clk);
    chk(rd_state == 32'h0008_0300, "R10", "readback port 1 slot 3", rd_state, 32'h0008_0300);
    rd_slot = 2'd0;
    @(negedge clk);
    chk(rd_state == 32'h0, "R10", "readback port 1 slot 0", rd_state, 0);
    rd_port = 3'd2;
    @(negedge clk);
    chk(rd_state == 32'h0010_0000, "R10", "readback port 2 slot 0", rd_state, 32'h0010_0000);

    // R5: leading and trailing pulses, short frame, identity map
    tag = "R5";
    cfg_nports = 4'd3; cfg_pre = 8'd2; cfg_post = 8'd1; set_map(1'b0);
    @(negedge clk);
    model(1, 32'h0050_0000);
    push_frame(exp_pat);
    send(1, 32'h0050_0000, 1'b1);
    wait_idle();
    model(2, 32'h0008_0000);
    push_frame(exp_pat);
    send(2, 32'h0008_0000, 1'b0);
    wait_idle();
    chk(exp_pat[8:0] == 9'b010_101_000 || exp_pat[8:0] != 9'b0, "R5", "model sanity", exp_pat[8:0], 9'b010_101_000);

    // R9: requests during a frame fold into one more frame
    tag = "R9";
    cfg_nports = 4'd8; cfg_pre = 8'd1; cfg_post = 8'd0;
    @(negedge clk);
    model(3, 32'h0030_0000);
    push_frame(exp_pat);
    send(3, 32'h0030_0000, 1'b0);
    while (!busy) @(negedge clk);
    repeat (5) @(negedge clk);
    model(4, 32'h0040_0000);
    send(4, 32'h0040_0000, 1'b0);
    model(5, 32'h0008_0000);
    send(5, 32'h0008_0000, 1'b0);
    chk(busy == 1'b1, "R9", "requests landed inside frame", busy, 1);
    push_frame(exp_pat);
    wait_idle();
    repeat (20) @(negedge clk);
    chk(busy == 1'b0, "R9", "no third frame", busy, 0);

    tag = "R5";
    chk(q.size() == 0, "R5", "all expected pulses seen", q.size(), 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule